// File: doc/BRIEF.md
# Seconds Real-Time Clock with Tick Event

This block holds a 32-bit count of seconds, with the count starting at midnight on 1 January 1904. A clock-cycle prescaler produces a one-second step. Each step adds one to the count and sends a single-cycle tick pulse to the interrupt collector. The reset value is a Unix time parameter plus 2082844800, which is the number of seconds from 1904 to 1970.

Software reaches the count through a byte-serial command frame:

- `cmdStart` opens a frame and samples `cmdSel`. A value of 0 selects read and 1 selects set.
- Each cycle with `argValid` high adds one argument byte.
- `cmdEnd` closes the frame.

A read takes no arguments and returns four bytes on `rspValid`/`rspData`, most significant byte first. A set takes exactly four bytes, most significant first. The block checks the argument count strictly and silently ignores any frame whose count is wrong.

Top module: `rtc_seconds_tick`

## Requirements
- R1: After reset, a read returns the parameter RESET_UNIX_TIME plus 2082844800, modulo 2^32. With the default parameter this is the bytes 0x7C 0x25 0xB0 0x80 in that order. No tick and no response is present during reset.
- R2: A frame with `cmdSel`=0 and zero argument bytes is a read. `rspValid` is high for four consecutive cycles, starting in the cycle after the clock edge that samples `cmdEnd`. Those cycles carry bits 31:24, 23:16, 15:8 and 7:0, in that order, of the count held just before that edge.
- R3: A read frame with one or more argument bytes produces no response and leaves the count unchanged.
- R4: A frame with `cmdSel`=1 and exactly four argument bytes is a set. The first byte is bits 31:24 and the last byte is bits 7:0. The value replaces the count at the edge that samples `cmdEnd`.
- R5: A set frame with zero, three, five or any other number of argument bytes other than four has no effect.
- R6: The count rises by one every CYCLES_PER_SEC clock cycles, on a fixed grid with no drift. `tickEvent` is high for exactly the one cycle after each increment.
- R7: A set restarts the prescaler, so the next increment and tick come exactly CYCLES_PER_SEC cycles after the load. If a load falls on the edge where a step was due, the load wins and no tick follows.
- R8: The count wraps from 0xFFFFFFFF to 0x00000000 and still raises a tick.
- R9: A read frame that closes while an earlier response still has bytes left to send is dropped. `cmdEnd` with no frame open does nothing. `cmdStart` while a frame is open restarts the frame. A byte presented in the same cycle as `cmdStart` or `cmdEnd` is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdStart | input | 1 | Opens a command frame |
| cmdSel | input | 1 | Operation, sampled with cmdStart: 0 read, 1 set |
| argValid | input | 1 | An argument byte is present on argData |
| argData | input | 8 | Argument byte |
| cmdEnd | input | 1 | Closes the open frame and executes it |
| rspValid | output | 1 | A response byte is present on rspData |
| rspData | output | 8 | Response byte, most significant first |
| tickEvent | output | 1 | One-cycle pulse after each one-second step |

## Verification
A wrong prescaler phase shows up at `tickEvent` within one second's worth of cycles. It appears either as a pulse on the wrong cycle or as a missing pulse after a set. A corrupted count or argument register is invisible at the ports until the next read frame. At that point the four response bytes differ from the reference count. The bench therefore reads after every kind of stimulus, and it places loads at every phase of the prescaler so that the collision between a load and a due step is reached. The frame-count and busy logic is seen at `rspValid` in the cycle after `cmdEnd`: a dropped or extra response burst differs on that cycle.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  typedef struct packed {
    logic doLoad;
    logic doStep;
    logic doSnap;
    logic doShift;
    logic argShift;
  } rtcStrobes_t;
endpackage

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
#(
  parameter int CYCLES_PER_SEC = 32768,
  parameter int NUM_BYTES      = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdStart,
  input  logic        cmdSel,
  input  logic        argValid,
  input  logic        cmdEnd,
  output rtcStrobes_t strobes,
  output logic        tickEvent,
  output logic        rspValid
);
  localparam int PRE_W = (CYCLES_PER_SEC > 2) ? $clog2(CYCLES_PER_SEC) : 1;
  localparam logic [PRE_W-1:0] PRE_MAX = PRE_W'(CYCLES_PER_SEC - 1);
  localparam int CNT_W = $clog2(NUM_BYTES + 2);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(NUM_BYTES + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(NUM_BYTES);
  localparam int LEFT_W = (NUM_BYTES > 2) ? $clog2(NUM_BYTES) : 1;
  localparam logic [LEFT_W-1:0] LEFT_START = LEFT_W'(NUM_BYTES - 1);

  logic [PRE_W-1:0]  preCnt;
  logic              frameOpen;
  logic              opSet;
  logic [CNT_W-1:0]  argCnt;
  logic [LEFT_W-1:0] rspLeft;
  logic              closeNow;
  logic              rspBusy;

  always_comb begin
    closeNow         = cmdEnd & frameOpen & ~cmdStart;
    rspBusy          = (rspLeft != '0);
    strobes.doLoad   = closeNow & opSet & (argCnt == CNT_FULL);
    strobes.doSnap   = closeNow & ~opSet & (argCnt == '0) & ~rspBusy;
    strobes.doStep   = ~strobes.doLoad & (preCnt == PRE_MAX);
    strobes.doShift  = rspBusy;
    strobes.argShift = argValid & frameOpen & ~cmdStart & ~cmdEnd;
  end

  // prescaler: restarts on a load or on reaching the end of a second
  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt    <= '0;
      tickEvent <= 1'b0;
    end else begin
      tickEvent <= strobes.doStep;
      if (strobes.doLoad || preCnt == PRE_MAX) preCnt <= '0;
      else                                      preCnt <= preCnt + 1'b1;
    end
  end

  // frame tracking with a saturating argument counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameOpen <= 1'b0;
      opSet     <= 1'b0;
      argCnt    <= '0;
    end else if (cmdStart) begin
      frameOpen <= 1'b1;
      opSet     <= cmdSel;
      argCnt    <= '0;
    end else if (closeNow) begin
      frameOpen <= 1'b0;
    end else if (strobes.argShift && argCnt != CNT_SAT) begin
      argCnt <= argCnt + 1'b1;
    end
  end

  // response sequencing
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspLeft  <= '0;
      rspValid <= 1'b0;
    end else if (strobes.doSnap) begin
      rspLeft  <= LEFT_START;
      rspValid <= 1'b1;
    end else if (rspBusy) begin
      rspLeft  <= rspLeft - 1'b1;
    end else begin
      rspValid <= 1'b0;
    end
  end
endmodule

// File: rtl/rtc_datapath.sv
module rtc_datapath
  import rtc_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int NUM_BYTES = 4,
  parameter logic [BYTE_W*NUM_BYTES-1:0] RESET_COUNT = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  rtcStrobes_t       strobes,
  input  logic [BYTE_W-1:0] argData,
  output logic [BYTE_W-1:0] rspData
);
  localparam int SEC_W = BYTE_W * NUM_BYTES;

  logic [SEC_W-1:0] secCount;
  logic [SEC_W-1:0] argReg;
  logic [SEC_W-1:0] rspReg;

  always_ff @(posedge clk) begin
    if (!rstN)                secCount <= RESET_COUNT;
    else if (strobes.doLoad)  secCount <= argReg;
    else if (strobes.doStep)  secCount <= secCount + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                  argReg <= '0;
    else if (strobes.argShift)  argReg <= {argReg[SEC_W-BYTE_W-1:0], argData};
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 rspReg <= '0;
    else if (strobes.doSnap)   rspReg <= secCount;
    else if (strobes.doShift)  rspReg <= {rspReg[SEC_W-BYTE_W-1:0], {BYTE_W{1'b0}}};
  end

  assign rspData = rspReg[SEC_W-1 -: BYTE_W];
endmodule

// File: rtl/rtc_seconds_tick.sv
module rtc_seconds_tick
  import rtc_pkg::*;
#(
  parameter int              CYCLES_PER_SEC  = 32768,
  parameter int              BYTE_W          = 8,
  parameter int              NUM_BYTES       = 4,
  parameter longint unsigned RESET_UNIX_TIME = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdStart,
  input  logic              cmdSel,
  input  logic              argValid,
  input  logic [BYTE_W-1:0] argData,
  input  logic              cmdEnd,
  output logic              rspValid,
  output logic [BYTE_W-1:0] rspData,
  output logic              tickEvent
);
  localparam int SEC_W = BYTE_W * NUM_BYTES;
  localparam longint unsigned EPOCH_SHIFT = 64'd2082844800;
  localparam logic [SEC_W-1:0] RESET_COUNT = SEC_W'(RESET_UNIX_TIME + EPOCH_SHIFT);

  rtcStrobes_t ctlStrobes;

  rtc_ctrl #(
    .CYCLES_PER_SEC(CYCLES_PER_SEC),
    .NUM_BYTES     (NUM_BYTES)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdStart (cmdStart),
    .cmdSel   (cmdSel),
    .argValid (argValid),
    .cmdEnd   (cmdEnd),
    .strobes  (ctlStrobes),
    .tickEvent(tickEvent),
    .rspValid (rspValid)
  );

  rtc_datapath #(
    .BYTE_W     (BYTE_W),
    .NUM_BYTES  (NUM_BYTES),
    .RESET_COUNT(RESET_COUNT)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(ctlStrobes),
    .argData(argData),
    .rspData(rspData)
  );
endmodule

// File: rtl/rtc_seconds_tick_chk.sv
module rtc_seconds_tick_chk #(
  parameter int CYCLES_PER_SEC = 32768
) (
  input logic clk,
  input logic rstN,
  input logic tickEvent,
  input logic rspValid,
  input logic doLoad,
  input logic doStep
);
  logic [31:0] gapCnt;

  always_ff @(posedge clk) begin
    if (!rstN)                   gapCnt <= '0;
    else if (doLoad || doStep)   gapCnt <= '0;
    else if (gapCnt != '1)       gapCnt <= gapCnt + 1'b1;
  end

  // R6: steps sit on a fixed grid measured from reset or the last load
  p_step_period_r6: assert property (@(posedge clk) disable iff (!rstN)
    doStep |-> gapCnt == 32'(CYCLES_PER_SEC - 1));

  // R6: every step is followed by a tick pulse
  p_tick_follows_r6: assert property (@(posedge clk) disable iff (!rstN)
    doStep |=> tickEvent);

  // R6: the tick lasts a single cycle
  p_tick_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    (tickEvent && CYCLES_PER_SEC > 1) |=> !tickEvent);

  // R7: a load suppresses the tick in the following cycle
  p_load_silences_r7: assert property (@(posedge clk) disable iff (!rstN)
    doLoad |=> !tickEvent);

  // R2: a response burst never lasts a single cycle
  p_rsp_burst_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rspValid) |=> rspValid);
endmodule

bind rtc_seconds_tick rtc_seconds_tick_chk #(
  .CYCLES_PER_SEC(CYCLES_PER_SEC)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .tickEvent(tickEvent),
  .rspValid (rspValid),
  .doLoad   (ctlStrobes.doLoad),
  .doStep   (ctlStrobes.doStep)
);

// File: tb/rtc_seconds_tick_bench.sv
module rtc_seconds_tick_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CYC        = 16;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmdStart = 1'b0;
  logic       cmdSel = 1'b0;
  logic       argValid = 1'b0;
  logic [7:0] argData = '0;
  logic       cmdEnd = 1'b0;
  logic       rspValid;
  logic [7:0] rspData;
  logic       tickEvent;

  int    vecCount = 0;
  int    errCount = 0;
  bit    done = 1'b0;
  string curReq = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_seconds_tick #(.CYCLES_PER_SEC(CYC)) u_rtc_seconds_tick (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .cmdSel(cmdSel),
    .argValid(argValid), .argData(argData), .cmdEnd(cmdEnd),
    .rspValid(rspValid), .rspData(rspData), .tickEvent(tickEvent)
  );

  // behavioural reference model
  logic [31:0] mSec;
  logic [31:0] mArg;
  int          mPre;
  bit          mOpen;
  bit          mOpSet;
  int          mCnt;
  logic [7:0]  rspQ[$];
  bit          expTick;
  bit          expValid;
  logic [7:0]  expData;

  always @(posedge clk) begin
    if (!rstN) begin
      mSec = 32'd2082844800; mArg = '0; mPre = 0; mOpen = 0; mOpSet = 0; mCnt = 0;
      rspQ.delete(); expTick = 0; expValid = 0; expData = '0;
    end else begin
      bit closeNow, load, snap, step, argIn;
      logic [31:0] oldSec;
      closeNow = cmdEnd && mOpen && !cmdStart;
      load  = closeNow && mOpSet && mCnt == 4;
      snap  = closeNow && !mOpSet && mCnt == 0 && rspQ.size() == 0;
      step  = !load && mPre == CYC - 1;
      argIn = argValid && mOpen && !cmdStart && !cmdEnd;
      oldSec = mSec;
      expTick = step;
      if (snap) begin
        rspQ.push_back(oldSec[31:24]); rspQ.push_back(oldSec[23:16]);
        rspQ.push_back(oldSec[15:8]);  rspQ.push_back(oldSec[7:0]);
      end
      if (rspQ.size() != 0) begin expValid = 1; expData = rspQ.pop_front(); end
      else expValid = 0;
      if (load)      begin mSec = mArg; mPre = 0; end
      else if (step) begin mSec = mSec + 1; mPre = 0; end
      else           mPre = mPre + 1;
      if (argIn) mArg = {mArg[23:0], argData};
      if (cmdStart)      begin mOpen = 1; mOpSet = cmdSel; mCnt = 0; end
      else if (closeNow) mOpen = 0;
      else if (argIn && mCnt < 5) mCnt = mCnt + 1;
    end
  end

  // comparison away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      vecCount++;
      if (!rstN) begin
        if (tickEvent !== 1'b0 || rspValid !== 1'b0) begin
          errCount++;
          $display("FAIL R1 reset outputs: tick=%b rspValid=%b expected 0 0", tickEvent, rspValid);
        end
      end else begin
        if (tickEvent !== expTick) begin
          errCount++;
          $display("FAIL %s tickEvent: actual %b expected %b at %0t", curReq, tickEvent, expTick, $time);
        end
        if (rspValid !== expValid) begin
          errCount++;
          $display("FAIL %s rspValid: actual %b expected %b at %0t", curReq, rspValid, expValid, $time);
        end else if (expValid && rspData !== expData) begin
          errCount++;
          $display("FAIL %s rspData: actual %h expected %h at %0t", curReq, rspData, expData, $time);
        end
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cmdStart = 0; cmdSel = 0; argValid = 0; cmdEnd = 0; argData = '0;
    end
  endtask

  task automatic frame(input bit sel, input int n, input logic [47:0] bytes);
    @(negedge clk);
    cmdStart = 1; cmdSel = sel; argValid = 0; cmdEnd = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cmdStart = 0; argValid = 1; argData = bytes[8*(n-1-i) +: 8];
    end
    @(negedge clk);
    cmdStart = 0; argValid = 0; cmdEnd = 1;
    @(negedge clk);
    cmdEnd = 0;
  endtask

  task automatic readNow();
    frame(1'b0, 0, '0);
    idle(5);
  endtask

  initial begin
    idle(3);
    @(negedge clk); rstN = 1;
    curReq = "R1"; readNow();
    curReq = "R2";
    for (int g = 0; g < 6; g++) begin idle(g * 3 + 1); readNow(); end
    curReq = "R3";
    frame(1'b0, 1, 48'h11); idle(5);
    frame(1'b0, 2, 48'h2233); idle(5);
    readNow();
    curReq = "R4";
    frame(1'b1, 4, 48'h12345678); readNow();
    frame(1'b1, 4, 48'hA5C30F1E); idle(CYC + 3); readNow();
    curReq = "R5";
    frame(1'b1, 0, '0); readNow();
    frame(1'b1, 3, 48'h0BADF0); readNow();
    frame(1'b1, 5, 48'hDEADBEEF77); readNow();
    curReq = "R6";
    idle(5 * CYC); readNow(); idle(3 * CYC + 7); readNow();
    curReq = "R7";
    for (int k = 0; k <= CYC + 1; k++) begin
      frame(1'b1, 4, 48'h00001000 + k); idle(k);
    end
    readNow(); idle(2 * CYC);
    curReq = "R8";
    frame(1'b1, 4, 48'hFFFFFFFE); idle(3 * CYC); readNow();
    curReq = "R9";
    frame(1'b0, 0, '0); frame(1'b0, 0, '0); idle(6);
    @(negedge clk); cmdEnd = 1; idle(4);
    @(negedge clk); cmdStart = 1; cmdSel = 1;
    @(negedge clk); cmdStart = 0; argValid = 1; argData = 8'h55;
    @(negedge clk); argValid = 1; cmdStart = 1; cmdSel = 0;
    @(negedge clk); cmdStart = 0; argValid = 0; cmdEnd = 1;
    idle(6); readNow(); idle(CYC);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecCount, errCount);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errCount++;
      $display("FAIL watchdog: run did not complete, actual hung expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vecCount, errCount);
      $finish;
    end
  end
endmodule